// File: doc/BRIEF.md
# Real-Time Clock with Link-Backed Configuration RAM

This block gives a host processor a PC-style clock-and-calendar plus a 32-byte configuration store, both reached through two byte-wide IO ports: a select port that latches a register index and a data port that reads or writes the register chosen by that index. A timer reference strobe drives a fractional prescaler whose long-run output is exactly one tick per second. Each tick advances the seconds, minutes, hours, day, month and year counters. Month lengths and leap years are handled.

The configuration bytes have no battery behind them. A two-wire link carries them instead. The wires are a link clock and a data line, driven by an external microcontroller. At power-up the controller streams all 32 bytes in. Later it can stream them back out to keep in its own non-volatile memory. The link engine has two named states. **LOAD**: the bus is locked out of the store and the engine shifts restore bytes in. **SERVE**: the bus may use the store and the engine shifts dump bytes out. Reset enters LOAD. LOAD moves to SERVE when the 32nd byte has been written. SERVE moves back to LOAD when the restore-mode input rises.

Top module: `rtc_nvram_top`

## Requirements
- R1: A write with `bus_sel`=0 latches `bus_wdata[6:0]` as the index. With `bus_sel`=1, a write stores `bus_wdata` into the indexed register, and `bus_rdata` shows that register. Time fields sit at these indices: seconds 0x00, minutes 0x02, hours 0x04, day 0x07, month 0x08, year 0x09. The store occupies 0x20 to 0x3F. Any other index reads 0x00.
- R2: Each `ref_stb` adds STEP to an accumulator. When the sum reaches OSC_HZ, one tick is issued and OSC_HZ is subtracted. From reset, OSC_HZ/gcd strobes therefore yield exactly STEP/gcd ticks. A tick appears only in the cycle that follows a strobe.
- R3: Seconds and minutes count 0 to 59 and hours count 0 to 23. Each field wraps to 0 and carries into the next field.
- R4: Day counts from 1 up to the month length. The month lengths are 31; 30 for months 4, 6, 9 and 11; and for month 2, 29 when the year is a multiple of 4 and 28 otherwise. After the last day, day returns to 1 and month advances. Month counts 1 to 12.
- R5: Year counts 0 to 99 in binary. After 31 December of year 99 comes 1 January of year 0.
- R6: The time counters change only on a tick or on a bus write.
- R7: A bus write to a time register in the same cycle as a tick takes effect. That tick is not lost: the counters advance in the following cycle, starting from the written value.
- R8: In LOAD with `lnk_restore`=1, each rising edge of `lnk_clk` shifts in `lnk_din`, most significant bit first. Each completed byte is stored at the next address, starting at address 0. After the 32nd byte, `nv_ready` goes to 1.
- R9: While `nv_ready`=0, the store reads 0x00 and ignores bus writes. A rising edge on `lnk_restore` while `nv_ready`=1 clears `nv_ready` and restarts the restore at address 0.
- R10: In SERVE with `lnk_restore`=0, `lnk_dout` presents the current bit of the store. Output starts at address 0, most significant bit first. Each rising edge of `lnk_clk` moves to the next bit, and after address 31 the address wraps to 0.
- R11: After reset, the time reads 00:00:00 on day 1, month 1, year 0, the index is 0, and `nv_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | Timer reference strobe, one cycle per reference period |
| bus_we | input | 1 | Port write strobe |
| bus_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Port write data |
| bus_rdata | output | 8 | Indexed register contents |
| lnk_clk | input | 1 | Link clock from the external controller (asynchronous) |
| lnk_din | input | 1 | Link data into the block |
| lnk_dout | output | 1 | Link data out of the block |
| lnk_restore | input | 1 | 1 = restore mode, 0 = dump mode |
| nv_ready | output | 1 | Store restored and open to the bus |

## Verification
The one-second tick and a bus write to a time register can arrive in the same cycle. The bench provokes this by counting reference strobes in its own accumulator model. It issues the strobe that completes a second and then places a seconds write in the very next cycle, which is the cycle in which the tick is raised. The result is correct when the seconds read back as the written value plus one, and wrong when they read back as the written value alone or as the old value plus one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam logic [6:0] IX_SEC   = 7'h00;
    localparam logic [6:0] IX_MIN   = 7'h02;
    localparam logic [6:0] IX_HOUR  = 7'h04;
    localparam logic [6:0] IX_DAY   = 7'h07;
    localparam logic [6:0] IX_MONTH = 7'h08;
    localparam logic [6:0] IX_YEAR  = 7'h09;
    localparam int         NV_BYTES = 32;

    typedef enum logic [0:0] {ST_LOAD, ST_SERVE} link_state_t;

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'd2:                          month_len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:       month_len = 8'd30;
            default:                       month_len = 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int OSC_HZ = 14318180,
    parameter int STEP   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_stb,
    output logic tick
);
    localparam int AW = $clog2(OSC_HZ + STEP + 1);
    localparam logic [AW-1:0] LIMIT = AW'(OSC_HZ);
    localparam logic [AW-1:0] INC   = AW'(STEP);

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;

    assign sum = acc + INC;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (ref_stb) begin
            if (sum >= LIMIT) begin
                acc  <= sum - LIMIT;
                tick <= 1'b1;
            end else begin
                acc  <= sum;
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr,
    input  logic [6:0] wr_idx,
    input  logic [7:0] wr_data,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hour,
    output logic [7:0] day,
    output logic [7:0] month,
    output logic [7:0] year,
    output logic       pend
);
    logic adv;
    logic end_min, end_hour, end_day, end_month, end_year;

    assign adv       = (tick | pend) & ~wr;
    assign end_min   = (sec == 8'd59);
    assign end_hour  = end_min & (min == 8'd59);
    assign end_day   = end_hour & (hour == 8'd23);
    assign end_month = end_day & (day >= month_len(month, year));
    assign end_year  = end_month & (month == 8'd12);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (wr && tick) begin
            pend <= 1'b1;
        end else if (adv) begin
            pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= 8'd0; min <= 8'd0; hour <= 8'd0;
            day <= 8'd1; month <= 8'd1; year <= 8'd0;
        end else if (wr) begin
            unique case (wr_idx)
                IX_SEC:   sec   <= wr_data;
                IX_MIN:   min   <= wr_data;
                IX_HOUR:  hour  <= wr_data;
                IX_DAY:   day   <= wr_data;
                IX_MONTH: month <= wr_data;
                IX_YEAR:  year  <= wr_data;
                default:  ;
            endcase
        end else if (adv) begin
            sec <= end_min ? 8'd0 : sec + 8'd1;
            if (end_min)   min   <= end_hour ? 8'd0 : min + 8'd1;
            if (end_hour)  hour  <= end_day ? 8'd0 : hour + 8'd1;
            if (end_day)   day   <= end_month ? 8'd1 : day + 8'd1;
            if (end_month) month <= end_year ? 8'd1 : month + 8'd1;
            if (end_year)  year  <= (year >= 8'd99) ? 8'd0 : year + 8'd1;
        end
    end
endmodule

// File: rtl/rtc_link.sv
module rtc_link
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lnk_clk,
    input  logic       lnk_din,
    input  logic       lnk_restore,
    output logic       lnk_dout,
    input  logic       bus_we,
    input  logic [4:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       open
);
    localparam int PW = $clog2(NV_BYTES);

    link_state_t   state, state_nx;
    logic [7:0]    ram [NV_BYTES];
    logic [2:0]    clk_sy, din_sy;
    logic          mode_q;
    logic          rise;
    logic [PW-1:0] ptr;
    logic [2:0]    bitn;
    logic [6:0]    shreg;
    logic          byte_done;

    assign rise      = clk_sy[1] & ~clk_sy[2];
    assign byte_done = rise & (bitn == 3'd7);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sy <= '0; din_sy <= '0; mode_q <= 1'b0;
        end else begin
            clk_sy <= {clk_sy[1:0], lnk_clk};
            din_sy <= {din_sy[1:0], lnk_din};
            mode_q <= lnk_restore;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:  if (lnk_restore && byte_done && ptr == PW'(NV_BYTES - 1)) state_nx = ST_SERVE;
            ST_SERVE: if (lnk_restore && !mode_q) state_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_nx != state) begin
            ptr <= '0; bitn <= '0; shreg <= '0;
        end else if (rise && (state == ST_LOAD) == lnk_restore) begin
            shreg <= {shreg[5:0], din_sy[1]};
            bitn  <= bitn + 3'd1;
            if (bitn == 3'd7) ptr <= ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_LOAD && lnk_restore && byte_done)
            ram[ptr] <= {shreg, din_sy[1]};
        else if (state == ST_SERVE && bus_we)
            ram[bus_addr] <= bus_wdata;
    end

    assign open      = (state == ST_SERVE);
    assign bus_rdata = open ? ram[bus_addr] : 8'h00;
    assign lnk_dout  = open & ram[ptr][~bitn];
endmodule

// File: rtl/rtc_nvram_top.sv
module rtc_nvram_top
    import rtc_pkg::*;
#(
    parameter int OSC_HZ = 14318180,
    parameter int STEP   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_stb,
    input  logic       bus_we,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       lnk_clk,
    input  logic       lnk_din,
    output logic       lnk_dout,
    input  logic       lnk_restore,
    output logic       nv_ready
);
    logic [6:0] idx;
    logic       tick, pend, time_wr, is_time, is_ram;
    logic [7:0] sec, min, hour, day, month, year, ram_rd;

    assign is_ram  = (idx[6:5] == 2'b01);
    assign is_time = (idx == IX_SEC) || (idx == IX_MIN) || (idx == IX_HOUR) ||
                     (idx == IX_DAY) || (idx == IX_MONTH) || (idx == IX_YEAR);
    assign time_wr = bus_we & bus_sel & is_time;

    always_ff @(posedge clk) begin
        if (!rst_n)                 idx <= '0;
        else if (bus_we && !bus_sel) idx <= bus_wdata[6:0];
    end

    rtc_prescaler #(.OSC_HZ(OSC_HZ), .STEP(STEP)) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .tick(tick)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr(time_wr), .wr_idx(idx),
        .wr_data(bus_wdata), .sec(sec), .min(min), .hour(hour), .day(day),
        .month(month), .year(year), .pend(pend)
    );

    rtc_link u_link (
        .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_din(lnk_din),
        .lnk_restore(lnk_restore), .lnk_dout(lnk_dout),
        .bus_we(bus_we & bus_sel & is_ram), .bus_addr(idx[4:0]),
        .bus_wdata(bus_wdata), .bus_rdata(ram_rd), .open(nv_ready)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (is_ram) bus_rdata = ram_rd;
        else begin
            unique case (idx)
                IX_SEC:   bus_rdata = sec;
                IX_MIN:   bus_rdata = min;
                IX_HOUR:  bus_rdata = hour;
                IX_DAY:   bus_rdata = day;
                IX_MONTH: bus_rdata = month;
                IX_YEAR:  bus_rdata = year;
                default:  bus_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_stb,
    input logic       tick,
    input logic       pend,
    input logic       time_wr,
    input logic       is_ram,
    input logic       bus_sel,
    input logic       nv_ready,
    input logic [7:0] bus_rdata,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hour,
    input logic [7:0] day,
    input logic [7:0] month
);
    p_tick_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(ref_stb));

    p_hms_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(time_wr) || (sec <= 8'd59 && min <= 8'd59 && hour <= 8'd23));

    p_date_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(time_wr) || (day >= 8'd1 && day <= 8'd31 && month >= 8'd1 && month <= 8'd12));

    p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !pend && !time_wr) |=> $stable(sec) && $stable(min) && $stable(day));

    p_deferred_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && time_wr) |=> pend);

    p_locked_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!nv_ready && is_ram && bus_sel) |-> bus_rdata == 8'h00);
endmodule

bind rtc_nvram_top rtc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .tick(tick), .pend(pend),
    .time_wr(time_wr), .is_ram(is_ram), .bus_sel(bus_sel), .nv_ready(nv_ready),
    .bus_rdata(bus_rdata), .sec(sec), .min(min), .hour(hour), .day(day), .month(month)
);

// File: tb/tb_rtc_nvram_top.sv
module tb_rtc_nvram_top;
    localparam int OSC = 50;
    localparam int STP = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_stb = 1'b0, bus_we = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic lnk_clk = 1'b0, lnk_din = 1'b0, lnk_restore = 1'b0;
    logic lnk_dout, nv_ready;

    int n_chk = 0, n_bad = 0, model_acc = 0;
    logic [7:0] pat [32];

    always #4 clk = ~clk;

    rtc_nvram_top #(.OSC_HZ(OSC), .STEP(STP)) dut (.*);

    // {year, month, day, hour, min, sec} before and after one tick
    localparam logic [47:0] V_IN [8] = '{
        {8'd24, 8'd2,  8'd28, 8'd23, 8'd59, 8'd59},   // R4 leap Feb 28
        {8'd24, 8'd2,  8'd29, 8'd23, 8'd59, 8'd59},   // R4 leap Feb 29
        {8'd23, 8'd2,  8'd28, 8'd23, 8'd59, 8'd59},   // R4 common Feb
        {8'd99, 8'd12, 8'd31, 8'd23, 8'd59, 8'd59},   // R5 year wrap
        {8'd25, 8'd4,  8'd30, 8'd23, 8'd59, 8'd59},   // R4 30-day month
        {8'd25, 8'd1,  8'd31, 8'd12, 8'd59, 8'd59},   // R3 hour carry
        {8'd25, 8'd6,  8'd15, 8'd10, 8'd20, 8'd30},   // R3 plain second
        {8'd25, 8'd1,  8'd30, 8'd23, 8'd59, 8'd59}    // R4 31-day month
    };
    localparam logic [47:0] V_OUT [8] = '{
        {8'd24, 8'd2,  8'd29, 8'd0,  8'd0,  8'd0},
        {8'd24, 8'd3,  8'd1,  8'd0,  8'd0,  8'd0},
        {8'd23, 8'd3,  8'd1,  8'd0,  8'd0,  8'd0},
        {8'd0,  8'd1,  8'd1,  8'd0,  8'd0,  8'd0},
        {8'd25, 8'd5,  8'd1,  8'd0,  8'd0,  8'd0},
        {8'd25, 8'd1,  8'd31, 8'd13, 8'd0,  8'd0},
        {8'd25, 8'd6,  8'd15, 8'd10, 8'd20, 8'd31},
        {8'd25, 8'd1,  8'd31, 8'd0,  8'd0,  8'd0}
    };
    localparam logic [6:0] FIELD_IX [6] = '{7'h09, 7'h08, 7'h07, 7'h04, 7'h02, 7'h00};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic port_wr(input logic sel, input logic [7:0] d);
        @(negedge clk); bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [6:0] ix, input logic [7:0] d);
        port_wr(1'b0, {1'b0, ix});
        port_wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [6:0] ix, output logic [7:0] d);
        port_wr(1'b0, {1'b0, ix});
        bus_sel = 1'b1;
        @(negedge clk); d = bus_rdata;
    endtask

    // one strobe; returns whether the bench model expects a tick from it
    task automatic strobe(output bit tk);
        @(negedge clk); ref_stb = 1'b1;
        model_acc += STP;
        tk = (model_acc >= OSC);
        if (tk) model_acc -= OSC;
        @(negedge clk); ref_stb = 1'b0;
    endtask

    task automatic one_second();
        bit tk;
        tk = 1'b0;
        while (!tk) strobe(tk);
        repeat (3) @(negedge clk);
    endtask

    task automatic lnk_bit_in(input logic b);
        lnk_din = b; repeat (4) @(negedge clk);
        lnk_clk = 1'b1; repeat (4) @(negedge clk);
        lnk_clk = 1'b0;
    endtask

    task automatic lnk_bit_out(output logic b);
        lnk_clk = 1'b0; repeat (4) @(negedge clk);
        b = lnk_dout;
        lnk_clk = 1'b1; repeat (4) @(negedge clk);
        lnk_clk = 1'b0;
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [47:0] got;
        logic [7:0] ob;
        logic ok;
        for (int i = 0; i < 32; i++) pat[i] = 8'hA5 ^ 8'(i * 37);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        check("R11 nv_ready", {63'd0, nv_ready}, 64'd0);
        bus_sel = 1'b1; @(negedge clk);
        check("R11 index/sec", {56'd0, bus_rdata}, 64'd0);
        reg_rd(7'h07, rd); check("R11 day", {56'd0, rd}, 64'd1);
        reg_rd(7'h08, rd); check("R11 month", {56'd0, rd}, 64'd1);

        // R2 fractional prescaler: 25 strobes of 12/50 give exactly 6 ticks
        for (int i = 0; i < 25; i++) begin
            bit tk;
            strobe(tk);
        end
        repeat (3) @(negedge clk);
        reg_rd(7'h00, rd); check("R2 25 strobes -> 6 s", {56'd0, rd}, 64'd6);

        // R1 unused index reads zero
        reg_wr(7'h05, 8'h77);
        reg_rd(7'h05, rd); check("R1 unused index", {56'd0, rd}, 64'd0);

        // R3 R4 R5 vector table
        for (int v = 0; v < 8; v++) begin
            for (int f = 0; f < 6; f++) reg_wr(FIELD_IX[f], V_IN[v][47 - 8*f -: 8]);
            one_second();
            for (int f = 0; f < 6; f++) begin
                reg_rd(FIELD_IX[f], rd);
                got[47 - 8*f -: 8] = rd;
            end
            check($sformatf("R3/R4/R5 vector %0d", v), {16'd0, got}, {16'd0, V_OUT[v]});
        end

        // R6 no tick, no write: time holds
        reg_rd(7'h00, ob);
        repeat (40) @(negedge clk);
        reg_rd(7'h00, rd); check("R6 hold without tick", {56'd0, rd}, {56'd0, ob});

        // R7 write collides with tick
        reg_wr(7'h00, 8'd10);
        port_wr(1'b0, 8'h00);
        begin
            bit tk;
            while (model_acc + STP < OSC) strobe(tk);
        end
        @(negedge clk); ref_stb = 1'b1; model_acc += STP - OSC;
        @(negedge clk); ref_stb = 1'b0; bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 8'd5;
        @(negedge clk); bus_we = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 collision write+1", {56'd0, bus_rdata}, 64'd6);

        // R9 locked store before restore
        reg_wr(7'h23, 8'h3C);
        reg_rd(7'h23, rd); check("R9 locked read/write", {56'd0, rd}, 64'd0);

        // R8 restore
        lnk_restore = 1'b1;
        for (int i = 0; i < 32; i++)
            for (int b = 7; b >= 0; b--) lnk_bit_in(pat[i][b]);
        repeat (4) @(negedge clk);
        check("R8 nv_ready after 32 bytes", {63'd0, nv_ready}, 64'd1);
        reg_rd(7'h20, rd); check("R8 byte 0", {56'd0, rd}, {56'd0, pat[0]});
        reg_rd(7'h25, rd); check("R8 byte 5", {56'd0, rd}, {56'd0, pat[5]});
        reg_rd(7'h3F, rd); check("R8 byte 31", {56'd0, rd}, {56'd0, pat[31]});
        reg_wr(7'h23, 8'h5A); pat[3] = 8'h5A;
        reg_rd(7'h23, rd); check("R1 store write", {56'd0, rd}, 64'h5A);

        // R10 dump, then wrap to byte 0
        lnk_restore = 1'b0;
        repeat (4) @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 33; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic bo;
                lnk_bit_out(bo);
                ob[b] = bo;
            end
            if (i < 32) begin
                if (ob !== pat[i]) ok = 1'b0;
            end else begin
                check("R10 dump wraps to byte 0", {56'd0, ob}, {56'd0, pat[0]});
            end
        end
        check("R10 dump 32 bytes", {63'd0, ok}, 64'd1);

        // R9 re-lock on restore rise
        lnk_restore = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 relock nv_ready", {63'd0, nv_ready}, 64'd0);
        reg_rd(7'h20, rd); check("R9 relocked read", {56'd0, rd}, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule